// File: doc/BRIEF.md
# Password Access Level Controller

This block decides which of three privilege levels a register bus currently holds. Software writes a 32-bit candidate password one byte at a time into four adjacent entry locations. The block compares the assembled candidate with two stored 32-bit passwords, which it receives as plain inputs from whatever holds them. A match with the second password gives the highest level. A match with only the first gives the middle level. Otherwise the bus stays at the base user level. A second stored password of all ones switches protection off and gives the highest level whatever was entered.

A register-bus arbiter asks the block, one access at a time, whether a read or a write to a given class of location is allowed. It passes the raw read byte through the block, and a refused read comes back as zero. The entry locations accept writes at every level but can never be read. The stored-password locations can never be read, and they can be written only at the highest level.

Top module: `pw_access_ctrl`

## Requirements
- R1: Entry byte k (k = 0..3) sits at address 7Bh+k, and byte 0 is the most significant byte of the 32-bit candidate. A write to any other address leaves the candidate unchanged.
- R2: Reset (synchronous, active high) sets the candidate to FFFFFFFFh. The level then follows from that value.
- R3: The level output is encoded 0 = user, 1 = level one, 2 = level two. A candidate equal to stored password 2 gives 2.
- R4: A candidate equal to stored password 1 gives 1. A candidate equal to both passwords gives 2. A candidate equal to neither gives 0.
- R5: When stored password 2 is FFFFFFFFh, the level is 2 for any candidate.
- R6: The level is re-evaluated from the register contents, so it changes in the clock cycle after an entry byte write. With no entry write and stable stored passwords, it holds.
- R7: Class code 4 (entry bytes) allows a write at every level and never allows a read.
- R8: Class code 5 (stored passwords) never allows a read and allows a write only at level 2.
- R9: q_rdata equals q_rdata_raw for an allowed read. It is 00h for a refused read and for any write query.
- R10: The other class codes are: 0 open (read and write at any level), 1 status (read at any level, write at level 2), 2 user data (read and write at level 1 or 2), 3 configuration (read and write at level 2). Codes 6 and 7 refuse everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| stored_pw1 | input | 32 | Current value of stored password 1 |
| stored_pw2 | input | 32 | Current value of stored password 2 |
| q_class | input | 3 | Location class of the queried access |
| q_write | input | 1 | 1 = write query, 0 = read query |
| q_rdata_raw | input | 8 | Unfiltered read byte from the addressed location |
| q_allow | output | 1 | Permission for the queried access |
| q_rdata | output | 8 | Read byte after permission filtering |
| level | output | 2 | Current access level |

## Verification
The hardest situation to reach is one where the candidate matches both stored passwords, or where protection is off while the candidate matches nothing. Both depend on the stored-password inputs rather than on any sequence of bus writes. The bench reaches them by changing the stored inputs between directed phases: it sets the two passwords equal, then forces password 2 to all ones with a junk candidate in place. The permission table is walked once at each of the three levels. Each level is set up first through real byte writes, in order, to the entry locations.

// File: rtl/pwacc_pkg.sv
package pwacc_pkg;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2
    } level_e;

    typedef enum logic [2:0] {
        CLS_OPEN     = 3'd0,
        CLS_STATUS   = 3'd1,
        CLS_USERDATA = 3'd2,
        CLS_CONFIG   = 3'd3,
        CLS_ENTRY    = 3'd4,
        CLS_PWSTORE  = 3'd5
    } acc_class_e;

    // minimum level for one direction; never = no level suffices
    typedef struct packed {
        logic   never;
        level_e min_lvl;
    } side_rule_t;

    typedef struct packed {
        side_rule_t rd;
        side_rule_t wr;
    } perm_rule_t;

    function automatic side_rule_t side(input logic never, input level_e min_lvl);
        side_rule_t s;
        s.never   = never;
        s.min_lvl = min_lvl;
        return s;
    endfunction

    function automatic perm_rule_t rule_of(input acc_class_e c);
        perm_rule_t r;
        case (c)
            CLS_OPEN:     begin r.rd = side(1'b0, LVL_USER); r.wr = side(1'b0, LVL_USER); end
            CLS_STATUS:   begin r.rd = side(1'b0, LVL_USER); r.wr = side(1'b0, LVL_TWO);  end
            CLS_USERDATA: begin r.rd = side(1'b0, LVL_ONE);  r.wr = side(1'b0, LVL_ONE);  end
            CLS_CONFIG:   begin r.rd = side(1'b0, LVL_TWO);  r.wr = side(1'b0, LVL_TWO);  end
            CLS_ENTRY:    begin r.rd = side(1'b1, LVL_TWO);  r.wr = side(1'b0, LVL_USER); end
            CLS_PWSTORE:  begin r.rd = side(1'b1, LVL_TWO);  r.wr = side(1'b0, LVL_TWO);  end
            default:      begin r.rd = side(1'b1, LVL_TWO);  r.wr = side(1'b1, LVL_TWO);  end
        endcase
        return r;
    endfunction

    function automatic logic side_grants(input side_rule_t s, input level_e lvl);
        return !s.never && (lvl >= s.min_lvl);
    endfunction

endpackage

// File: rtl/pwacc_entry_reg.sv
module pwacc_entry_reg #(
    parameter int PW_BYTES = 4,
    parameter int BYTE_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int BASE     = 'h7B,
    localparam int PW_W    = PW_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [PW_W-1:0]   entry_q
);
    // slot 0 is the most significant byte
    for (genvar k = 0; k < PW_BYTES; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE + k);
        localparam int                HI        = PW_W - 1 - k * BYTE_W;
        logic [BYTE_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '1;
            end else if (wr_en && (wr_addr == SLOT_ADDR)) begin
                byte_q <= wr_data;
            end
        end

        assign entry_q[HI -: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/pwacc_level_eval.sv
module pwacc_level_eval
    import pwacc_pkg::*;
#(
    parameter int PW_W = 32
) (
    input  logic [PW_W-1:0] entry_q,
    input  logic [PW_W-1:0] pw1,
    input  logic [PW_W-1:0] pw2,
    output level_e          lvl
);
    logic prot_off;
    logic hit_two;
    logic hit_one;

    always_comb begin
        prot_off = &pw2;
        hit_two  = (entry_q == pw2);
        hit_one  = (entry_q == pw1);
        if (prot_off || hit_two) begin
            lvl = LVL_TWO;
        end else if (hit_one) begin
            lvl = LVL_ONE;
        end else begin
            lvl = LVL_USER;
        end
    end
endmodule

// File: rtl/pwacc_perm_check.sv
module pwacc_perm_check
    import pwacc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        q_class,
    input  logic              q_write,
    input  level_e            lvl,
    input  logic [DATA_W-1:0] q_rdata_raw,
    output logic              q_allow,
    output logic [DATA_W-1:0] q_rdata
);
    perm_rule_t rule;

    always_comb begin
        rule    = rule_of(acc_class_e'(q_class));
        q_allow = q_write ? side_grants(rule.wr, lvl) : side_grants(rule.rd, lvl);
        q_rdata = (!q_write && q_allow) ? q_rdata_raw : '0;
    end
endmodule

// File: rtl/pw_access_ctrl.sv
module pw_access_ctrl
    import pwacc_pkg::*;
#(
    parameter int PW_BYTES   = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int ENTRY_BASE = 'h7B,
    localparam int PW_W      = PW_BYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW_W-1:0]   stored_pw1,
    input  logic [PW_W-1:0]   stored_pw2,
    input  logic [2:0]        q_class,
    input  logic              q_write,
    input  logic [DATA_W-1:0] q_rdata_raw,
    output logic              q_allow,
    output logic [DATA_W-1:0] q_rdata,
    output logic [1:0]        level
);
    logic [PW_W-1:0] entry_q;
    level_e          lvl;

    pwacc_entry_reg #(
        .PW_BYTES (PW_BYTES),
        .BYTE_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE     (ENTRY_BASE)
    ) u_entry (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .entry_q (entry_q)
    );

    pwacc_level_eval #(
        .PW_W (PW_W)
    ) u_eval (
        .entry_q (entry_q),
        .pw1     (stored_pw1),
        .pw2     (stored_pw2),
        .lvl     (lvl)
    );

    pwacc_perm_check #(
        .DATA_W (DATA_W)
    ) u_perm (
        .q_class     (q_class),
        .q_write     (q_write),
        .lvl         (lvl),
        .q_rdata_raw (q_rdata_raw),
        .q_allow     (q_allow),
        .q_rdata     (q_rdata)
    );

    assign level = lvl;
endmodule

// File: rtl/pwacc_checker.sv
module pwacc_checker #(
    parameter int PW_BYTES   = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int ENTRY_BASE = 'h7B,
    localparam int PW_W      = PW_BYTES * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [PW_W-1:0]   stored_pw1,
    input logic [PW_W-1:0]   stored_pw2,
    input logic [2:0]        q_class,
    input logic              q_write,
    input logic              q_allow,
    input logic [DATA_W-1:0] q_rdata,
    input logic [1:0]        level,
    input logic [PW_W-1:0]   entry_q
);
    logic entry_write;
    assign entry_write = wr_en
                      && (wr_addr >= ADDR_W'(ENTRY_BASE))
                      && (wr_addr <  ADDR_W'(ENTRY_BASE + PW_BYTES));

    // R2: candidate is all ones in the first cycle out of reset
    a_r2_reset_ones: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (entry_q == {PW_W{1'b1}}));

    // R5: protection off forces level two
    a_r5_prot_off: assert property (@(posedge clk) disable iff (rst)
        (&stored_pw2) |-> (level == 2'd2));

    // R6: level holds without entry writes and with stable stored values
    a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
        !entry_write |=> ((level == $past(level))
                          || !$stable(stored_pw1) || !$stable(stored_pw2)));

    // R7: entry bytes are writable at any level and never readable
    a_r7_entry_wr: assert property (@(posedge clk) disable iff (rst)
        (q_class == 3'd4 && q_write) |-> q_allow);
    a_r7_entry_rd: assert property (@(posedge clk) disable iff (rst)
        (q_class == 3'd4 && !q_write) |-> !q_allow);

    // R8: stored passwords never read, written only at level two
    a_r8_store_rd: assert property (@(posedge clk) disable iff (rst)
        (q_class == 3'd5 && !q_write) |-> !q_allow);
    a_r8_store_wr: assert property (@(posedge clk) disable iff (rst)
        (q_class == 3'd5 && q_write && level != 2'd2) |-> !q_allow);

    // R9: refused reads return zero
    a_r9_zero_data: assert property (@(posedge clk) disable iff (rst)
        !q_allow |-> (q_rdata == '0));

    // R3: level encoding never reaches 3
    a_r3_level_code: assert property (@(posedge clk) disable iff (rst)
        level != 2'd3);
endmodule

bind pw_access_ctrl pwacc_checker #(
    .PW_BYTES   (PW_BYTES),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .ENTRY_BASE (ENTRY_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .stored_pw1 (stored_pw1),
    .stored_pw2 (stored_pw2),
    .q_class    (q_class),
    .q_write    (q_write),
    .q_allow    (q_allow),
    .q_rdata    (q_rdata),
    .level      (level),
    .entry_q    (entry_q)
);

// File: tb/pw_access_ctrl_tb.sv
`timescale 1ns/1ps
module pw_access_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [31:0] stored_pw1;
    logic [31:0] stored_pw2;
    logic [2:0]  q_class;
    logic        q_write;
    logic [7:0]  q_rdata_raw;
    logic        q_allow;
    logic [7:0]  q_rdata;
    logic [1:0]  level;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] PW_A = 32'h1122_3344;
    localparam logic [31:0] PW_B = 32'hA5A5_5A5A;

    // {class[2:0], write, min level[1:0]}; min level 3 = never
    localparam logic [5:0] VEC [0:11] = '{
        {3'd0, 1'b0, 2'd0}, {3'd0, 1'b1, 2'd0},
        {3'd1, 1'b0, 2'd0}, {3'd1, 1'b1, 2'd2},
        {3'd2, 1'b0, 2'd1}, {3'd2, 1'b1, 2'd1},
        {3'd3, 1'b0, 2'd2}, {3'd3, 1'b1, 2'd2},
        {3'd4, 1'b0, 2'd3}, {3'd4, 1'b1, 2'd0},
        {3'd5, 1'b0, 2'd3}, {3'd5, 1'b1, 2'd2}
    };

    always #2.5 clk = ~clk;

    pw_access_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .stored_pw1  (stored_pw1),
        .stored_pw2  (stored_pw2),
        .q_class     (q_class),
        .q_write     (q_write),
        .q_rdata_raw (q_rdata_raw),
        .q_allow     (q_allow),
        .q_rdata     (q_rdata),
        .level       (level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) begin
            put_byte(8'h7B + 8'(k), w[31 - 8*k -: 8]);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        if (c == 3'd4) return "R7";
        if (c == 3'd5) return "R8";
        return "R10";
    endfunction

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
        stored_pw1 = PW_A; stored_pw2 = PW_B;
        q_class = 3'd0; q_write = 1'b0; q_rdata_raw = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1 check("R2 reset level user", 32'(level), 32'd0);

        // R1 partial candidate, then full password 1
        put_byte(8'h7B, 8'h11);
        put_byte(8'h7C, 8'h22);
        put_byte(8'h7D, 8'h33);
        check("R1 partial candidate", 32'(level), 32'd0);
        put_byte(8'h7E, 8'h44);
        check("R4 pw1 match level one", 32'(level), 32'd1);

        // R1 neighbouring addresses ignored
        put_byte(8'h7A, 8'h00);
        put_byte(8'h7F, 8'h00);
        check("R1 out-of-range write ignored", 32'(level), 32'd1);

        // R6 hold over idle cycles
        repeat (5) @(posedge clk);
        #1 check("R6 level holds", 32'(level), 32'd1);

        // R1 byte order: reversed bytes must not match
        put_word(32'h4433_2211);
        check("R1 msb first order", 32'(level), 32'd0);

        // permission table at each level
        for (int lv = 0; lv < 3; lv++) begin
            if (lv == 0) put_word(32'h0000_0000);
            else if (lv == 1) put_word(PW_A);
            else put_word(PW_B);
            check("R3 level setup", 32'(level), 32'(lv));
            for (int i = 0; i < 12; i++) begin
                q_class = VEC[i][5:3];
                q_write = VEC[i][2];
                q_rdata_raw = 8'hC3;
                #1;
                check(tag_of(VEC[i][5:3]), 32'(q_allow),
                      32'((VEC[i][1:0] != 2'd3) && (lv >= int'(VEC[i][1:0]))));
            end
        end

        // R9 read data filtering (level two now)
        q_class = 3'd3; q_write = 1'b0; q_rdata_raw = 8'h5E; #1;
        check("R9 allowed read passes data", 32'(q_rdata), 32'h5E);
        q_class = 3'd4; q_write = 1'b0; #1;
        check("R9 refused read is zero", 32'(q_rdata), 32'h00);
        q_class = 3'd0; q_write = 1'b1; #1;
        check("R9 write query data zero", 32'(q_rdata), 32'h00);
        q_class = 3'd6; q_write = 1'b0; #1;
        check("R10 code 6 refused", 32'(q_allow), 32'd0);
        q_class = 3'd7; q_write = 1'b1; #1;
        check("R10 code 7 refused", 32'(q_allow), 32'd0);

        // R4 both passwords equal -> level two
        @(negedge clk);
        stored_pw1 = PW_B;
        #1 check("R4 both match level two", 32'(level), 32'd2);
        stored_pw1 = PW_A;

        // R5 protection off with a junk candidate
        put_word(32'hDEAD_BEEF);
        check("R3 junk candidate user", 32'(level), 32'd0);
        @(negedge clk);
        stored_pw2 = 32'hFFFF_FFFF;
        #1 check("R5 protection off level two", 32'(level), 32'd2);
        q_class = 3'd5; q_write = 1'b1; #1;
        check("R8 store write with protection off", 32'(q_allow), 32'd1);
        stored_pw2 = PW_B;

        // R2 reset mid-operation restores all-ones candidate
        put_word(PW_A);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R2 reset clears level", 32'(level), 32'd0);
        @(negedge clk);
        stored_pw1 = 32'hFFFF_FFFF;
        #1 check("R2 reset candidate all ones", 32'(level), 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule